// File: doc/BRIEF.md
# Lookup-Table Signed Multiplier

This block multiplies two 4-bit two's complement operands. It does no arithmetic at run time. Every possible product sits in a 256-word by 8-bit read-only table. The table contents are computed at elaboration time from the two halves of each address. The two operands are joined into an 8-bit read address, with the multiplier in the upper nibble and the multiplicand in the lower nibble. The registered table output is the product.

Operands enter through a valid/ready stream and products leave through another. The only storage is one output stage. A pair is accepted when `in_valid` and `in_ready` are both high at a rising edge. Its product is presented with `out_valid` from that same edge onward. `in_ready` is high whenever the output stage is empty or the consumer takes the current product in this cycle. When the consumer holds `out_ready` low, the product stays frozen and the block stops accepting new operands.

The data register has no reset. Its only control is a read enable, so it maps onto a synchronous block memory read port.

Top module: `lutmul_rom_mult`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: For every operand pair, `out_product` equals the low 8 bits of the product of `in_mplier` and `in_mcand`, both taken as signed 4-bit values (range -8..7).
- R3: A pair accepted at a rising edge gives `out_valid` = 1 with its product after that same edge, which is a latency of exactly one clock.
- R4: The operand pair -8 times -8 (both 4'h8) yields 8'h40.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_product` stays unchanged on the following cycle.
- R6: `in_ready` is 0 whenever `out_valid` is 1 and `out_ready` is 0.
- R7: When the current product is taken (or the stage is empty) and `in_valid` is 0, `out_valid` is 0 after the edge.
- R8: Operands presented while `in_ready` is 0 are not accepted and do not alter the product being held.
- R9: With `out_ready` held at 1, a new pair is accepted on every cycle and the products emerge in the order the pairs were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the valid flag |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can accept an operand pair |
| in_mplier | input | 4 | Signed multiplier, upper address nibble |
| in_mcand | input | 4 | Signed multiplicand, lower address nibble |
| out_valid | output | 1 | Product present |
| out_ready | input | 1 | Consumer takes the product |
| out_product | output | 8 | Signed product |

## Verification
Each product is due on the first rising edge after the edge that accepted its operands. The bench drives inputs on the falling edge. Shortly after that it records which pairs will be accepted and pushes their expected products into a queue. A monitor runs a little later in the same low phase. It pops and compares a result only when `out_valid` and `out_ready` are both high, so the one-clock latency and the stall periods both line up with the queue order. During a stall the monitor also checks that the held product and `out_valid` did not move since the previous cycle, and that `in_ready` is low.

// File: rtl/lutmul_pkg.sv
package lutmul_pkg;
  localparam int OP_W   = 4;
  localparam int ADDR_W = 2 * OP_W;
  localparam int PROD_W = 2 * OP_W;
  localparam int DEPTH  = 1 << ADDR_W;

  // Table word for one address: upper half times lower half, both signed.
  function automatic logic [PROD_W-1:0] table_word(input logic [ADDR_W-1:0] addr);
    logic [OP_W-1:0]          hi_bits;
    logic [OP_W-1:0]          lo_bits;
    logic signed [PROD_W-1:0] hi_ext;
    logic signed [PROD_W-1:0] lo_ext;
    logic signed [PROD_W-1:0] prod;
    hi_bits = addr[ADDR_W-1:OP_W];
    lo_bits = addr[OP_W-1:0];
    hi_ext  = {{OP_W{hi_bits[OP_W-1]}}, hi_bits};
    lo_ext  = {{OP_W{lo_bits[OP_W-1]}}, lo_bits};
    prod    = hi_ext * lo_ext;
    return prod;
  endfunction
endpackage

// File: rtl/lutmul_rom.sv
module lutmul_rom
  import lutmul_pkg::*;
(
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [PROD_W-1:0] rd_data
);
  logic [PROD_W-1:0] rom_tbl [DEPTH];

  // Constant contents, evaluated at elaboration.
  for (genvar i = 0; i < DEPTH; i++) begin : g_fill
    assign rom_tbl[i] = table_word(ADDR_W'(i));
  end

  // Synchronous read with an enable and no reset, in the shape of a block memory port.
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= rom_tbl[rd_addr];
  end
endmodule

// File: rtl/lutmul_stage_ctrl.sv
module lutmul_stage_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic load_en,
  output logic out_valid
);
  logic valid_q;

  assign in_ready  = !valid_q || out_ready;
  assign load_en   = in_ready && in_valid;
  assign out_valid = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        valid_q <= 1'b0;
    else if (in_ready) valid_q <= in_valid;
  end
endmodule

// File: rtl/lutmul_rom_mult.sv
module lutmul_rom_mult
  import lutmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_mplier,
  input  logic [OP_W-1:0]   in_mcand,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PROD_W-1:0] out_product
);
  logic              load_en;
  logic [ADDR_W-1:0] rom_addr;

  // Multiplier in the upper nibble, multiplicand in the lower nibble.
  assign rom_addr = {in_mplier, in_mcand};

  lutmul_stage_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .load_en   (load_en),
    .out_valid (out_valid)
  );

  lutmul_rom u_rom (
    .clk     (clk),
    .rd_en   (load_en),
    .rd_addr (rom_addr),
    .rd_data (out_product)
  );
endmodule

// File: rtl/lutmul_rom_mult_chk.sv
module lutmul_rom_mult_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [3:0] in_mplier,
  input logic [3:0] in_mcand,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_product
);
  logic signed [7:0] ref_prod;
  assign ref_prod = $signed(in_mplier) * $signed(in_mcand);

  // R2, R3: an accepted pair shows its signed product one clock later
  a_r3_product_next: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_product == $past(ref_prod)));

  // R5: a stalled product is held
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_product)));

  // R6: no acceptance while stalled
  a_r6_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7: a bubble empties the stage
  a_r7_drain: assert property (@(posedge clk) disable iff (!rst_n)
    ((!out_valid || out_ready) && !in_valid) |=> !out_valid);

  // R4: the most negative pair
  a_r4_corner: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mplier == 4'h8 && in_mcand == 4'h8) |=> (out_product == 8'h40));
endmodule

bind lutmul_rom_mult lutmul_rom_mult_chk u_chk (.*);

// File: tb/lutmul_rom_mult_tb.sv
module lutmul_rom_mult_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [3:0] in_mplier;
  logic [3:0] in_mcand;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_product;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct packed { logic [3:0] a; logic [3:0] b; logic [7:0] p; } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  lutmul_rom_mult u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mplier(in_mplier), .in_mcand(in_mcand), .out_valid(out_valid),
    .out_ready(out_ready), .out_product(out_product)
  );

  function automatic logic [7:0] model(input logic [3:0] a, input logic [3:0] b);
    int sa;
    int sb;
    int p;
    sa = a[3] ? int'(a) - 16 : int'(a);
    sb = b[3] ? int'(b) - 16 : int'(b);
    p  = sa * sb;
    return p[7:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: set inputs on the falling edge, then record what the next edge accepts.
  task automatic drive(input bit v, input logic [3:0] a, input logic [3:0] b, input bit rdy);
    @(negedge clk);
    in_valid  = v;
    in_mplier = a;
    in_mcand  = b;
    out_ready = rdy;
    #0.5;
    if (v && in_ready) sb_q.push_back('{a: a, b: b, p: model(a, b)});
  endtask

  // Monitor: runs after the driver in each low phase.
  bit         prev_stall = 1'b0;
  logic [7:0] prev_prod;
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (prev_stall) begin
        check("R5 valid held", {31'd0, out_valid}, 32'd1);
        check("R5 product held", {24'd0, out_product}, {24'd0, prev_prod});
      end
      if (out_valid && !out_ready)
        check("R6 in_ready low in stall", {31'd0, in_ready}, 32'd0);
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) check("R9 unexpected output", 32'd1, 32'd0);
        else begin
          item_t it;
          it = sb_q.pop_front();
          if (it.a == 4'h8 && it.b == 4'h8)
            check("R4 -8*-8", {24'd0, out_product}, 32'h40);
          else
            check("R2 R3 R8 product", {24'd0, out_product}, {24'd0, it.p});
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_prod  = out_product;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_mplier = '0; in_mcand = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);

    // R9 and R2: full-rate sweep over all pairs
    for (int i = 0; i < 256; i++) drive(1'b1, i[7:4], i[3:0], 1'b1);

    // R5, R6, R8: irregular consumer, shifting operands during stalls
    for (int i = 0; i < 60; i++) drive(1'b1, 4'(i * 5 + 3), 4'(i * 11 + 8), (i % 3) != 0);
    drive(1'b1, 4'h8, 4'h8, 1'b0);
    drive(1'b1, 4'h8, 4'h8, 1'b1);

    // R7: bubble drains the stage
    drive(1'b0, 4'h7, 4'h7, 1'b1);
    drive(1'b0, 4'h7, 4'h7, 1'b1);
    #2;
    check("R7 out_valid after drain", {31'd0, out_valid}, 32'd0);
    check("R9 queue empty", sb_q.size(), 32'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule